// File: doc/BRIEF.md
# Dual-Strobe Loadable Address Counter

This block keeps an address for stepping through a memory. It is driven by two strobes that arrive without a fixed relation to the system clock. A high-to-low transition on the load strobe captures a start address from the data input. A low-to-high transition on the advance strobe moves the counter on. The first advance after a load commits the captured start address into the counter. Every later advance adds one to the counter.

Both strobes are brought into the single system clock domain through multi-flop synchronizers. Edges are then found by comparing each synchronized sample with the one before it, so every flop runs on the same clock edge. While a captured start address waits for its commit, the output already presents that address. A memory can therefore read the start location before the first advance arrives. The data input must be held stable from the load strobe's falling transition until the output has updated, which takes three clock edges.

Top module: `addr_strobe_counter`

## Requirements
- R1: After reset is released, the address output is 0 and no load is pending, so the first advance edge gives 1.
- R2: A falling edge on the load strobe stores the data input as the start address, marks a load as pending, and makes the output show that start address.
- R3: A rising edge on the advance strobe while a load is pending copies the start address into the counter, so the output keeps that value. The next advance edge gives start address plus one.
- R4: A rising edge on the advance strobe with no load pending adds one to the counter.
- R5: Incrementing from 255 gives 0.
- R6: The pending mark is cleared for as long as the synchronized advance strobe is high. A load falling edge that arrives while the advance strobe is high stores the start address, but the output keeps the counter value, and the next advance edge increments the counter.
- R7: If a load falling edge and an advance rising edge are detected in the same clock cycle, the counter takes the newly loaded data, not an increment.
- R8: A strobe transition changes the output on the third rising clock edge after the input changes: two synchronizer edges, then one register edge. The output does not change on the first two edges.
- R9: A rising edge of the load strobe, a falling edge of the advance strobe, and changes of the data input without a load edge all leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_stb_i | input | 1 | Asynchronous load strobe, acts on its falling transition |
| adv_stb_i | input | 1 | Asynchronous advance strobe, acts on its rising transition |
| data_i | input | 8 | Start address presented with the load strobe |
| addr_o | output | 8 | Registered address: the pending start address, else the counter |

## Verification
The output has two possible sources: the counter and the held start address. A fault in either one becomes visible within one advance edge. A pending mark that is stuck or cleared too early shows up as an increment where a commit was due, or as a start address that never appears on the output. A wrong capture shows up three clock edges after the load strobe falls, as an output that differs from the data input. Latency faults in the synchronizer or the edge detector move the output change off its expected clock edge, so the bench samples the output on each of the three edges after a strobe transition.

// File: rtl/asc_pkg.sv
package asc_pkg;
  localparam int unsigned ADDR_W_DEF    = 8;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } strobe_ev_t;

  localparam int unsigned N_STROBES = 2;
  localparam int unsigned IDX_LOAD  = 0;
  localparam int unsigned IDX_ADV   = 1;
endpackage

// File: rtl/asc_sync.sv
module asc_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [DEPTH-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[DEPTH-1];
endmodule

// File: rtl/asc_edge.sv
module asc_edge
  import asc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_i,
  output strobe_ev_t ev_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_i;
  end

  always_comb begin
    ev_o.level = sync_i;
    ev_o.rise  = sync_i & ~prev_q;
    ev_o.fall  = ~sync_i & prev_q;
  end

  // A detected edge lasts exactly one cycle (supports R8 timing)
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
    ev_o.rise |=> !ev_o.rise);
  assert_fall_single_R8: assert property (@(posedge clk) disable iff (rst)
    ev_o.fall |=> !ev_o.fall);
endmodule

// File: rtl/asc_core.sv
module asc_core #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_fall_i,
  input  logic              adv_rise_i,
  input  logic              adv_level_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    // Load is taken first, so a coincident advance sees the new address.
    start_d = load_fall_i ? data_i : start_q;
    pend_d  = adv_level_i ? 1'b0 : (load_fall_i | pend_q);
    cnt_d   = cnt_q;
    if (adv_rise_i) begin
      if (pend_q || load_fall_i) cnt_d = start_d;
      else                       cnt_d = cnt_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= '0;
      pend_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
      pend_q  <= pend_d;
      addr_q  <= pend_d ? start_d : cnt_d;
    end
  end

  assign addr_o = addr_q;

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load_fall_i |=> start_q == $past(data_i));
  assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_rise_i && pend_q && !load_fall_i) |=> cnt_q == $past(start_q));
  assert_increment_R4: assert property (@(posedge clk) disable iff (rst)
    (adv_rise_i && !pend_q && !load_fall_i) |=> cnt_q == $past(cnt_q) + ADDR_W'(1));
  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (rst)
    adv_level_i |=> !pend_q);
  assert_coincide_R7: assert property (@(posedge clk) disable iff (rst)
    (load_fall_i && adv_rise_i) |=> addr_o == $past(data_i));
  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!load_fall_i && !adv_rise_i && !adv_level_i) |=> $stable(addr_o));
endmodule

// File: rtl/addr_strobe_counter.sv
module addr_strobe_counter
  import asc_pkg::*;
#(
  parameter int unsigned ADDR_W     = ADDR_W_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_stb_i,
  input  logic              adv_stb_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [N_STROBES-1:0] raw;
  logic [N_STROBES-1:0] synced;
  strobe_ev_t           ev [N_STROBES];

  assign raw[IDX_LOAD] = load_stb_i;
  assign raw[IDX_ADV]  = adv_stb_i;

  genvar s;
  generate
    for (s = 0; s < N_STROBES; s++) begin : g_strobe
      asc_sync #(.DEPTH(SYNC_DEPTH)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw[s]),
        .sync_o  (synced[s])
      );
      asc_edge edge_i (
        .clk    (clk),
        .rst    (rst),
        .sync_i (synced[s]),
        .ev_o   (ev[s])
      );
    end
  endgenerate

  logic load_lvl_unused, load_rise_unused, adv_fall_unused;
  assign load_lvl_unused  = ev[IDX_LOAD].level;
  assign load_rise_unused = ev[IDX_LOAD].rise;
  assign adv_fall_unused  = ev[IDX_ADV].fall;

  asc_core #(.ADDR_W(ADDR_W)) core_i (
    .clk         (clk),
    .rst         (rst),
    .load_fall_i (ev[IDX_LOAD].fall),
    .adv_rise_i  (ev[IDX_ADV].rise),
    .adv_level_i (ev[IDX_ADV].level),
    .data_i      (data_i),
    .addr_o      (addr_o)
  );
endmodule

// File: tb/addr_strobe_counter_tb.sv
module addr_strobe_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       load_stb, adv_stb;
  logic [7:0] data;
  logic [7:0] addr;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #2 clk = ~clk;

  addr_strobe_counter dut_i (
    .clk(clk), .rst(rst), .load_stb_i(load_stb), .adv_stb_i(adv_stb),
    .data_i(data), .addr_o(addr)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (addr !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%02h expected=%02h", req, addr, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] v);
    data = v; load_stb = 1'b0; tick(4);
    load_stb = 1'b1; tick(4);
  endtask

  task automatic do_adv();
    adv_stb = 1'b1; tick(4);
    adv_stb = 1'b0; tick(4);
  endtask

  task automatic t_reset();
    rst = 1'b1; load_stb = 1'b1; adv_stb = 1'b0; data = 8'h00;
    tick(3); rst = 1'b0; tick(4);
    check("R1 reset value", 8'h00);
    do_adv();
    check("R1 no pending after reset", 8'h01);
  endtask

  task automatic t_load_latency();
    @(negedge clk);
    data = 8'h40; load_stb = 1'b0;
    tick(1); check("R8 edge 1 unchanged", 8'h01);
    tick(1); check("R8 edge 2 unchanged", 8'h01);
    tick(1); check("R2/R8 start shown on edge 3", 8'h40);
    load_stb = 1'b1; tick(4);
    check("R9 load rise ignored", 8'h40);
    data = 8'h13; tick(4);
    check("R9 data change ignored", 8'h40);
  endtask

  task automatic t_commit_increment();
    adv_stb = 1'b1; tick(4);
    check("R3 commit keeps start", 8'h40);
    adv_stb = 1'b0; tick(4);
    check("R9 advance fall ignored", 8'h40);
    do_adv();
    check("R3 start plus one", 8'h41);
    do_adv();
    check("R4 increment", 8'h42);
  endtask

  task automatic t_load_while_adv_high();
    adv_stb = 1'b1; tick(4);
    check("R4 increment on rise", 8'h43);
    do_load(8'h90);
    check("R6 load under high advance keeps counter", 8'h43);
    adv_stb = 1'b0; tick(4);
    do_adv();
    check("R6 next advance increments", 8'h44);
  endtask

  task automatic t_wrap();
    do_load(8'hFF);
    check("R2 start ff shown", 8'hFF);
    do_adv();
    check("R3 commit ff", 8'hFF);
    do_adv();
    check("R5 wrap to 00", 8'h00);
  endtask

  task automatic t_coincide();
    do_adv();
    check("R4 before coincidence", 8'h01);
    @(negedge clk);
    data = 8'hA5; load_stb = 1'b0; adv_stb = 1'b1;
    tick(4);
    check("R7 coincident edges take data", 8'hA5);
    load_stb = 1'b1; adv_stb = 1'b0; tick(4);
    do_adv();
    check("R7 counter holds new data", 8'hA6);
  endtask

  initial begin
    t_reset();
    t_load_latency();
    t_commit_increment();
    t_load_while_adv_high();
    t_wrap();
    t_coincide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule